// File: doc/BRIEF.md
# DS3 M23 Transmit Frame Generator

This block sits in the transmit path of a DS3 line interface and turns a serial bitstream into a correctly framed M23 signal. Bits arrive one per clock enable, with a strobe that marks the first bit of a frame. The block tracks the bit position inside the 4760-bit frame. A frame holds 7 subframes. Each subframe holds 8 blocks, and each block is one overhead bit followed by 84 payload bits. The block then replaces the overhead slots with generated values. Payload bits are never altered.

Control inputs choose what gets generated. Full frame generation writes the alignment bits and the remote defect indication. The parity bits can be generated on their own, even when frame generation is off. The C-bit pattern has its own enable. The remote defect indication comes from the alarm inputs through a per-alarm mask, or it can be forced to a constant. The output is registered, so each result bit appears one clock after its input bit, together with a valid flag and a frame-start flag.

Top module: `ds3_tx_framer`

## Requirements
- R1: A frame is 4760 bits: 7 subframes × 8 blocks × (1 overhead bit + 84 payload bits). The bit position restarts at 0 on every enabled bit with `sof_in` high, and wraps from 4759 to 0 when no strobe is given. `sof_out` is high exactly with the output bit of frame position 0.
- R2: With `frame_gen_en` high, the four F slots of every subframe (blocks 1, 3, 5 and 7) carry 1, 0, 0, 1 in that order.
- R3: With `frame_gen_en` high, the first overhead slot of subframes 5, 6 and 7 carries the M-bits 0, 1, 0.
- R4: With `frame_gen_en` high and `rdi_mode` 00 or 11, both X-bits (first slot of subframes 1 and 2) are 0 while any alarm whose mask bit is set is active, and 1 otherwise. The mask bits are: bit0 LOS, bit1 SEF, bit2 LOF, bit3 AIS.
- R5: `rdi_mode` 01 forces both X-bits to 1 and `rdi_mode` 10 forces them to 0, whatever the alarm inputs are.
- R6: When `frame_gen_en` or `pbit_gen_en` is high, both P-bits (first slot of subframes 3 and 4) carry the XOR of all payload bits of the previous frame. Overhead slots are not part of this sum. In the first frame after reset the P-bits are 0.
- R7: With `frame_gen_en` and `cbit_gen_en` both high, C11 (block 2 of subframe 1) is 1 in the first frame after reset and alternates on each later frame. All other C slots (blocks 2, 4 and 6) are 0.
- R8: With `frame_gen_en` high and `cbit_gen_en` low, the C slots pass the input bit unchanged.
- R9: With `frame_gen_en` low, every slot passes the input bit, except the P slots when `pbit_gen_en` is high.
- R10: Payload bits always leave the block unchanged.
- R11: Each output bit appears one clock after its enabled input bit, with `out_valid` high. In a cycle that follows a clock with `bit_en` low, `out_valid` is low, `data_out` holds its value and the bit position does not advance.
- R12: After synchronous reset, `data_out`, `out_valid` and `sof_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One input bit is present this cycle |
| sof_in | input | 1 | Current input bit is frame position 0 |
| data_in | input | 1 | Serial input bit |
| frame_gen_en | input | 1 | Generate F, M, X and P bits |
| pbit_gen_en | input | 1 | Generate P bits alone |
| cbit_gen_en | input | 1 | Generate C-bit pattern (needs frame_gen_en) |
| rdi_mode | input | 2 | 00/11 automatic, 01 force 1, 10 force 0 |
| rdi_mask | input | 4 | Alarm enables: bit0 LOS, bit1 SEF, bit2 LOF, bit3 AIS |
| alarm_los | input | 1 | Loss of signal active |
| alarm_sef | input | 1 | Severely errored frame active |
| alarm_lof | input | 1 | Loss of frame active |
| alarm_ais | input | 1 | Alarm indication signal active |
| data_out | output | 1 | Serial output bit |
| out_valid | output | 1 | data_out carries a new bit |
| sof_out | output | 1 | data_out is frame position 0 |

## Verification
Random payload is sent through the block under several control settings, and every output bit is compared against its expected value. Full generation with C-bits on shows that the F, M, X, P and C slots are decoded at the right positions and given the right values. The same traffic is also run with C-bits off, with only P-bit generation, and with no generation at all. These runs show which slots each enable owns. Alarm and mask combinations separate the automatic remote defect indication from the forced modes. A run with enable gaps and a mid-frame strobe shows that the position counter holds while no bit is present and restarts on the strobe. The parity latched from a partial frame also shows up in the next frame's P-bits.

// File: rtl/ds3_txf_pkg.sv
package ds3_txf_pkg;
  typedef enum logic [2:0] {
    SLOT_PAY,
    SLOT_F,
    SLOT_M,
    SLOT_X,
    SLOT_P,
    SLOT_C
  } slot_e;

  typedef enum logic [1:0] {
    RDI_AUTO  = 2'b00,
    RDI_ONE   = 2'b01,
    RDI_ZERO  = 2'b10,
    RDI_AUTO2 = 2'b11
  } rdi_mode_e;
endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos #(
  parameter int SUBF = 7,
  parameter int BLKS = 8,
  parameter int PAYB = 84,
  localparam int BLK_LEN = PAYB + 1,
  localparam int SUB_W = $clog2(SUBF),
  localparam int BLK_W = $clog2(BLKS),
  localparam int BIT_W = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             sof_in,
  output logic [SUB_W-1:0] cur_sub,
  output logic [BLK_W-1:0] cur_blk,
  output logic [BIT_W-1:0] cur_bit,
  output logic             frame_start
);
  logic [SUB_W-1:0] cnt_sub;
  logic [BLK_W-1:0] cnt_blk;
  logic [BIT_W-1:0] cnt_bit;

  // the strobe overrides the running count for the current bit
  always_comb begin
    cur_sub = sof_in ? '0 : cnt_sub;
    cur_blk = sof_in ? '0 : cnt_blk;
    cur_bit = sof_in ? '0 : cnt_bit;
    frame_start = (cur_sub == '0) && (cur_blk == '0) && (cur_bit == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_sub <= '0;
      cnt_blk <= '0;
      cnt_bit <= '0;
    end else if (bit_en) begin
      if (cur_bit == BIT_W'(BLK_LEN - 1)) begin
        cnt_bit <= '0;
        if (cur_blk == BLK_W'(BLKS - 1)) begin
          cnt_blk <= '0;
          cnt_sub <= (cur_sub == SUB_W'(SUBF - 1)) ? '0 : cur_sub + 1'b1;
        end else begin
          cnt_blk <= cur_blk + 1'b1;
          cnt_sub <= cur_sub;
        end
      end else begin
        cnt_bit <= cur_bit + 1'b1;
        cnt_blk <= cur_blk;
        cnt_sub <= cur_sub;
      end
    end
  end
endmodule

// File: rtl/ds3_slot_decode.sv
module ds3_slot_decode
  import ds3_txf_pkg::*;
#(
  parameter int SUB_W = 3,
  parameter int BLK_W = 3,
  parameter int BIT_W = 7
) (
  input  logic [SUB_W-1:0] cur_sub,
  input  logic [BLK_W-1:0] cur_blk,
  input  logic [BIT_W-1:0] cur_bit,
  output slot_e            slot,
  output logic             fixed_val,
  output logic             is_c11
);
  logic [BLK_W-1:0] f_idx;

  always_comb begin
    slot      = SLOT_PAY;
    fixed_val = 1'b0;
    is_c11    = 1'b0;
    f_idx     = cur_blk >> 1;
    if (cur_bit == '0) begin
      if (cur_blk == '0) begin
        // first slot of subframe: X X P P M M M
        if (cur_sub < SUB_W'(2))      slot = SLOT_X;
        else if (cur_sub < SUB_W'(4)) slot = SLOT_P;
        else begin
          slot      = SLOT_M;
          fixed_val = (cur_sub == SUB_W'(5));
        end
      end else if (cur_blk[0]) begin
        // alignment pattern 1 0 0 1 over the four F slots
        slot      = SLOT_F;
        fixed_val = (f_idx == '0) || (f_idx == BLK_W'(3));
      end else begin
        slot   = SLOT_C;
        is_c11 = (cur_sub == '0) && (cur_blk == BLK_W'(2));
      end
    end
  end
endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic frame_start,
  input  logic is_payload,
  input  logic bit_val,
  output logic p_prev
);
  logic acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= 1'b0;
      p_prev <= 1'b0;
    end else if (bit_en) begin
      if (frame_start) begin
        p_prev <= acc;
        acc    <= 1'b0;
      end else if (is_payload) begin
        acc <= acc ^ bit_val;
      end
    end
  end
endmodule

// File: rtl/ds3_tx_framer.sv
module ds3_tx_framer
  import ds3_txf_pkg::*;
#(
  parameter int SUBF = 7,
  parameter int BLKS = 8,
  parameter int PAYB = 84
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       sof_in,
  input  logic       data_in,
  input  logic       frame_gen_en,
  input  logic       pbit_gen_en,
  input  logic       cbit_gen_en,
  input  logic [1:0] rdi_mode,
  input  logic [3:0] rdi_mask,
  input  logic       alarm_los,
  input  logic       alarm_sef,
  input  logic       alarm_lof,
  input  logic       alarm_ais,
  output logic       data_out,
  output logic       out_valid,
  output logic       sof_out
);
  localparam int SUB_W = $clog2(SUBF);
  localparam int BLK_W = $clog2(BLKS);
  localparam int BIT_W = $clog2(PAYB + 1);

  logic [SUB_W-1:0] cur_sub;
  logic [BLK_W-1:0] cur_blk;
  logic [BIT_W-1:0] cur_bit;
  logic             frame_start;
  slot_e            slot;
  logic             fixed_val;
  logic             is_c11;
  logic             p_prev;
  logic             c11_phase;
  logic             alarm_hit;
  logic             rdi_bit;
  logic             gen_bit;

  ds3_frame_pos #(.SUBF(SUBF), .BLKS(BLKS), .PAYB(PAYB)) u_pos (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sof_in(sof_in),
    .cur_sub(cur_sub), .cur_blk(cur_blk), .cur_bit(cur_bit),
    .frame_start(frame_start)
  );

  ds3_slot_decode #(.SUB_W(SUB_W), .BLK_W(BLK_W), .BIT_W(BIT_W)) u_dec (
    .cur_sub(cur_sub), .cur_blk(cur_blk), .cur_bit(cur_bit),
    .slot(slot), .fixed_val(fixed_val), .is_c11(is_c11)
  );

  // payload passes unchanged, so the input bit equals the output bit there
  ds3_parity_acc u_par (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_start(frame_start),
    .is_payload(slot == SLOT_PAY), .bit_val(data_in), .p_prev(p_prev)
  );

  always_ff @(posedge clk) begin
    if (rst)                       c11_phase <= 1'b0;
    else if (bit_en && frame_start) c11_phase <= ~c11_phase;
  end

  always_comb begin
    alarm_hit = |(rdi_mask & {alarm_ais, alarm_lof, alarm_sef, alarm_los});
    unique case (rdi_mode_e'(rdi_mode))
      RDI_ONE:  rdi_bit = 1'b1;
      RDI_ZERO: rdi_bit = 1'b0;
      default:  rdi_bit = ~alarm_hit;
    endcase
  end

  always_comb begin
    gen_bit = data_in;
    unique case (slot)
      SLOT_F, SLOT_M: if (frame_gen_en) gen_bit = fixed_val;
      SLOT_X:         if (frame_gen_en) gen_bit = rdi_bit;
      SLOT_P:         if (frame_gen_en || pbit_gen_en) gen_bit = p_prev;
      SLOT_C:         if (frame_gen_en && cbit_gen_en) gen_bit = is_c11 & c11_phase;
      default:        gen_bit = data_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out  <= 1'b0;
      out_valid <= 1'b0;
      sof_out   <= 1'b0;
    end else begin
      out_valid <= bit_en;
      if (bit_en) begin
        data_out <= gen_bit;
        sof_out  <= frame_start;
      end else begin
        sof_out  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ds3_tx_framer_chk.sv
module ds3_tx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_en,
  input logic       sof_in,
  input logic       data_in,
  input logic       frame_gen_en,
  input logic       pbit_gen_en,
  input logic       cbit_gen_en,
  input logic [1:0] rdi_mode,
  input logic [3:0] rdi_mask,
  input logic       alarm_los,
  input logic       alarm_sef,
  input logic       alarm_lof,
  input logic       alarm_ais,
  input logic       data_out,
  input logic       out_valid,
  input logic       sof_out
);
  AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    sof_out |-> out_valid); // R1
  AST_STROBE_TO_SOF: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sof_in) |=> sof_out); // R1
  AST_EN_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> out_valid); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> (!out_valid && $stable(data_out))); // R11
  AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !frame_gen_en && !pbit_gen_en) |=> (data_out == $past(data_in))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_out && !out_valid && !sof_out)); // R12
endmodule

bind ds3_tx_framer ds3_tx_framer_chk u_chk (.*);

// File: tb/tb_ds3_tx_framer.sv
module tb_ds3_tx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 4760;
  localparam int SUB_BITS   = 680;
  localparam int BLK_BITS   = 85;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, sof_in = 1'b0, data_in = 1'b0;
  logic frame_gen_en = 1'b1, pbit_gen_en = 1'b0, cbit_gen_en = 1'b1;
  logic [1:0] rdi_mode = 2'b00;
  logic [3:0] rdi_mask = 4'hF;
  logic alarm_los = 1'b0, alarm_sef = 1'b0, alarm_lof = 1'b0, alarm_ais = 1'b0;
  logic data_out, out_valid, sof_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds3_tx_framer dut (.*);

  int total = 0;
  int bad = 0;

  // category bookkeeping: 0 pay 1 F 2 M 3 X 4 P 5 C 6 sof 7 timing
  int    cat_n   [8];
  int    cat_bad [8];
  string cat_tag [8];
  int    cat_act [8];
  int    cat_exp [8];

  // bench frame model
  int pos = 0;
  int frames = 0;
  bit acc = 0, prev_par = 0;
  bit pend = 0, pend_bit = 0, pend_sof = 0;
  int pend_cat = 0;
  bit last_out = 0;

  task automatic note(int c, string tag, int act, int exp_v);
    cat_n[c]++;
    cat_tag[c] = tag;
    if (act != exp_v) begin
      if (cat_bad[c] == 0) begin
        cat_act[c] = act;
        cat_exp[c] = exp_v;
      end
      cat_bad[c]++;
    end
  endtask

  task automatic flush(string scen);
    for (int c = 0; c < 8; c++) begin
      if (cat_n[c] > 0) begin
        total++;
        if (cat_bad[c] > 0) begin
          bad++;
          $display("FAIL %s %s: %0d mismatches, first actual=%0d expected=%0d",
                   cat_tag[c], scen, cat_bad[c], cat_act[c], cat_exp[c]);
        end
      end
      cat_n[c] = 0;
      cat_bad[c] = 0;
    end
  endtask

  task automatic single(string tag, int act, int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // compare output of the bit driven at the previous negedge
  task automatic check_pending();
    if (pend) begin
      note(7, "R11", out_valid, 1);
      note(6, "R1", sof_out, pend_sof);
      case (pend_cat)
        0: note(0, "R10", data_out, pend_bit);
        1: note(1, frame_gen_en ? "R2" : "R9", data_out, pend_bit);
        2: note(2, frame_gen_en ? "R3" : "R9", data_out, pend_bit);
        3: note(3, !frame_gen_en ? "R9" : (rdi_mode == 2'b01 || rdi_mode == 2'b10) ? "R5" : "R4",
                data_out, pend_bit);
        4: note(4, (frame_gen_en || pbit_gen_en) ? "R6" : "R9", data_out, pend_bit);
        default: note(5, !frame_gen_en ? "R9" : cbit_gen_en ? "R7" : "R8", data_out, pend_bit);
      endcase
      last_out = data_out;
    end else begin
      note(7, "R11", out_valid, 0);
      note(7, "R11", data_out, last_out);
    end
  endtask

  task automatic drive_bit(bit sof, bit d);
    int sub, rem, blk, b, cat;
    bit e, alarm;
    if (sof) pos = 0;
    if (pos == 0) begin
      prev_par = acc;
      acc = 0;
      frames++;
    end
    sub = pos / SUB_BITS;
    rem = pos % SUB_BITS;
    blk = rem / BLK_BITS;
    b   = rem % BLK_BITS;
    alarm = (rdi_mask[0] & alarm_los) | (rdi_mask[1] & alarm_sef) |
            (rdi_mask[2] & alarm_lof) | (rdi_mask[3] & alarm_ais);
    e = d;
    if (b != 0) cat = 0;
    else if (blk == 0 && sub <= 1) cat = 3;
    else if (blk == 0 && sub <= 3) cat = 4;
    else if (blk == 0) cat = 2;
    else if (blk % 2 == 1) cat = 1;
    else cat = 5;
    case (cat)
      1: if (frame_gen_en) e = (blk == 1 || blk == 7);
      2: if (frame_gen_en) e = (sub == 5);
      3: if (frame_gen_en) e = (rdi_mode == 2'b01) ? 1'b1 : (rdi_mode == 2'b10) ? 1'b0 : !alarm;
      4: if (frame_gen_en || pbit_gen_en) e = prev_par;
      5: if (frame_gen_en && cbit_gen_en) e = (sub == 0 && blk == 2) ? frames[0] : 1'b0;
      default: ;
    endcase
    if (cat == 0) acc ^= d;
    pend = 1;
    pend_bit = e;
    pend_sof = (pos == 0);
    pend_cat = cat;
    bit_en = 1;
    sof_in = sof;
    data_in = d;
    pos = (pos + 1) % FRAME_BITS;
  endtask

  // n bits; strobe at index sof_a and sof_b (-1 for none); idle cycle every gap bits (0 none)
  task automatic run_bits(int n, int sof_a, int sof_b, int gap);
    for (int i = 0; i < n; i++) begin
      if (gap != 0 && i != 0 && (i % gap) == 0) begin
        @(negedge clk);
        check_pending();
        pend = 0;
        bit_en = 0;
        sof_in = 0;
      end
      @(negedge clk);
      check_pending();
      drive_bit(i == sof_a || i == sof_b, 1'($urandom & 1));
    end
    @(negedge clk);
    check_pending();
    pend = 0;
    bit_en = 0;
    sof_in = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    bit_en = 0;
    sof_in = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    pos = 0; frames = 0; acc = 0; prev_par = 0; pend = 0; last_out = 0;
  endtask

  task automatic t_reset();
    do_reset();
    single("R12 data_out", data_out, 0);
    single("R12 out_valid", out_valid, 0);
    single("R12 sof_out", sof_out, 0);
  endtask

  task automatic t_full();
    frame_gen_en = 1; pbit_gen_en = 0; cbit_gen_en = 1;
    rdi_mode = 2'b00; rdi_mask = 4'hF;
    {alarm_los, alarm_sef, alarm_lof, alarm_ais} = 4'b0000;
    do_reset();
    run_bits(2 * FRAME_BITS + 10, 0, -1, 0);  // wrap without a second strobe
    flush("full generation");
  endtask

  task automatic t_alarm();
    frame_gen_en = 1; cbit_gen_en = 1; rdi_mode = 2'b00;
    do_reset();
    rdi_mask = 4'b0001; alarm_los = 1;       // enabled alarm: X = 0
    run_bits(FRAME_BITS, 0, -1, 0);
    flush("LOS enabled");
    alarm_los = 0; alarm_sef = 1; alarm_ais = 1; // masked alarms: X = 1
    run_bits(FRAME_BITS, 0, -1, 0);
    flush("alarms masked");
    rdi_mask = 4'b1000;                      // AIS enabled: X = 0
    run_bits(FRAME_BITS, 0, -1, 0);
    flush("AIS enabled");
    alarm_sef = 0; alarm_ais = 0;
  endtask

  task automatic t_forced();
    frame_gen_en = 1; cbit_gen_en = 1; rdi_mask = 4'hF;
    do_reset();
    rdi_mode = 2'b01; alarm_lof = 1;
    run_bits(FRAME_BITS, 0, -1, 0);
    flush("RDI forced one");
    rdi_mode = 2'b10; alarm_lof = 0;
    run_bits(FRAME_BITS, 0, -1, 0);
    flush("RDI forced zero");
    rdi_mode = 2'b00;
  endtask

  task automatic t_cbit_off();
    frame_gen_en = 1; cbit_gen_en = 0;
    do_reset();
    run_bits(2 * FRAME_BITS, 0, FRAME_BITS, 0);
    flush("C-bits off");
    cbit_gen_en = 1;
  endtask

  task automatic t_pass();
    frame_gen_en = 0; pbit_gen_en = 1; cbit_gen_en = 1;
    do_reset();
    run_bits(2 * FRAME_BITS, 0, FRAME_BITS, 0);
    flush("P-bits only");
    pbit_gen_en = 0;
    run_bits(FRAME_BITS, 0, -1, 0);
    flush("no generation");
    frame_gen_en = 1;
  endtask

  task automatic t_gaps_realign();
    frame_gen_en = 1; pbit_gen_en = 0; cbit_gen_en = 1;
    do_reset();
    run_bits(6000, 0, 2000, 7);  // idle cycles, strobe mid-frame
    flush("gaps and realign");
  endtask

  initial begin
    t_reset();
    t_full();
    t_alarm();
    t_forced();
    t_cbit_off();
    t_pass();
    t_gaps_realign();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule